// File: doc/BRIEF.md
# Parallel-Port Nibble Register Bridge

This block sits on the device side of a standard PC parallel port. It gives a host access to a peripheral register space with a 7-bit address. The host drives the 8-bit data lines and three control lines: select-in, autofeed and strobe. It reads data back on the status lines. Each transaction opens when select-in is cleared. While autofeed is low, the byte on the data lines is the address byte. Setting autofeed locks that address and enters a data phase. Each strobe pulse then makes exactly one access to the internal register bus.

Writes commit the data byte on each rising strobe. Reads return one byte in two nibbles on the status pins, with the bits permuted. The low nibble appears while strobe is high and the high nibble after strobe falls. Repeated strobes in one transaction reuse the same address, which is how the host empties or fills FIFO registers. The control lines and the data lines pass through synchronizers before any edge is detected. The data byte is sampled one clock after the control change that qualifies it.

Top module: `ppnib_bridge`

## Requirements
- R1: After reset, the bridge is idle. It issues no read or write pulse, and all eight status bits are 0.
- R2: Select-in high means idle. Setting it at any point aborts the transaction. With select-in high, strobe activity causes no bus access. The next transaction must latch a fresh address byte.
- R3: The address byte is latched on the rising edge of autofeed. Bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 6:0 form the register address.
- R4: In a write transaction, each rising strobe issues exactly one write pulse. The pulse carries the data-line byte to the latched address.
- R5: The address stays fixed for the whole transaction. N strobe pulses give N accesses to that same address (burst for FIFO registers).
- R6: In a read transaction, each rising strobe issues exactly one read pulse. Read and write pulses never coincide.
- R7: In a read transaction, while strobe is high the status pins carry the low nibble of the read byte, and while strobe is low they carry the high nibble. The pin map is nibble bit 3 → status 3, bit 2 → status 4, bit 1 → status 5, bit 0 → status 7 (pin level, not inverted). Status bit 6 and bits 2:0 are always 0.
- R8: Both nibbles of one read come from the same bus access. The byte is held even if the register changes after the access.
- R9: A read burst from a FIFO address returns the successive FIFO bytes, one per strobe.
- R10: All 7 address bits pass to the bus unchanged, including wrapped window addresses such as 0x60, 0x7F and 0x1E.
- R11: Strobe pulses during the address phase, before autofeed rises, cause no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bridge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_data_i | input | 8 | Host data lines |
| host_sel_i | input | 1 | Select-in control bit (1 = idle) |
| host_afd_i | input | 1 | Autofeed control bit (1 = data phase) |
| host_stb_i | input | 1 | Strobe control bit |
| host_stat_o | output | 8 | Status lines; bits 7,5,4,3 carry the nibble, others 0 |
| bus_addr_o | output | 7 | Internal bus register address |
| bus_wdata_o | output | 8 | Internal bus write data |
| bus_we_o | output | 1 | One-cycle write pulse |
| bus_re_o | output | 1 | One-cycle read pulse |
| bus_rdata_i | input | 8 | Read data, valid the cycle after bus_re_o |

## Verification
The bench uses the default parameters: a 7-bit address, an 8-bit data path and a two-stage synchronizer. This puts the full address space within reach, including the top of the wrapped window at 0x7F and the three FIFO addresses at 0x1E, 0x3E and 0x5E. The bench holds each host control step for ten clocks. That is longer than the synchronizer latency plus the one-clock data sample and the registered read return, so each step reaches its settled state. Random single writes and read-backs mix with directed cases. The directed cases are aborts, strobes in the address phase, single-bit nibble patterns, FIFO bursts, and a register that changes between the two nibbles.

// File: rtl/ppnib_pkg.sv
package ppnib_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_WDATA = 2'd2,
    PH_RDATA = 2'd3
  } phase_e;
endpackage

// File: rtl/ppnib_sync.sv
module ppnib_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ppnib_nib_enc.sv
module ppnib_nib_enc #(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic              hi_sel_i,
  input  logic              en_i,
  output logic [7:0]        stat_o
);
  logic [NIB_W-1:0] nib;

  assign nib = hi_sel_i ? byte_i[DATA_W-1:NIB_W] : byte_i[NIB_W-1:0];

  // nibble bit k -> status pin; bit 0 lands on the busy pin at its true level
  always_comb begin
    stat_o = '0;
    if (en_i) begin
      stat_o[3] = nib[3];
      stat_o[4] = nib[2];
      stat_o[5] = nib[1];
      stat_o[7] = nib[0];
    end
  end
endmodule

// File: rtl/ppnib_core.sv
module ppnib_core
  import ppnib_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              afd_i,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              re_o,
  output logic [DATA_W-1:0] rbyte_o,
  output logic              rd_phase_o,
  output logic              hi_sel_o
);
  phase_e            phase_q;
  logic              afd_d, stb_d;
  logic              pend_addr_q, pend_wr_q, cap_q;
  logic              we_q, re_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rbyte_q;
  logic              afd_rise, stb_rise;

  assign afd_rise = afd_i & ~afd_d;
  assign stb_rise = stb_i & ~stb_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      afd_d       <= 1'b0;
      stb_d       <= 1'b0;
      pend_addr_q <= 1'b0;
      pend_wr_q   <= 1'b0;
      cap_q       <= 1'b0;
      we_q        <= 1'b0;
      re_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rbyte_q     <= '0;
    end else begin
      afd_d     <= afd_i;
      stb_d     <= stb_i;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      pend_addr_q <= 1'b0;
      pend_wr_q <= 1'b0;
      cap_q     <= re_q;
      if (cap_q) rbyte_q <= rdata_i;
      if (sel_i) begin
        phase_q <= PH_IDLE;
      end else begin
        unique case (phase_q)
          PH_IDLE: phase_q <= PH_ADDR;
          PH_ADDR: begin
            pend_addr_q <= afd_rise;
            if (pend_addr_q) begin
              addr_q  <= data_i[ADDR_W-1:0];
              phase_q <= data_i[DATA_W-1] ? PH_RDATA : PH_WDATA;
            end
          end
          PH_WDATA: begin
            pend_wr_q <= stb_rise;
            if (pend_wr_q) begin
              we_q    <= 1'b1;
              wdata_q <= data_i;
            end
          end
          PH_RDATA: re_q <= stb_rise;
          default:  phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign we_o       = we_q;
  assign re_o       = re_q;
  assign rbyte_o    = rbyte_q;
  assign rd_phase_o = (phase_q == PH_RDATA);
  assign hi_sel_o   = ~stb_i;

  // R2
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |=> phase_q == PH_IDLE);

  // R4
  wr_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> $past(phase_q) == PH_WDATA);

  // R6
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_q |=> !re_q);

  // R6
  rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_q && re_q));

  // R5
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_WDATA || phase_q == PH_RDATA) && $past(phase_q) == phase_q)
      |-> $stable(addr_q));

  // R11
  addr_phase_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ADDR && $past(phase_q) == PH_ADDR) |-> !we_q && !re_q);
endmodule

// File: rtl/ppnib_bridge.sv
module ppnib_bridge #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              host_sel_i,
  input  logic              host_afd_i,
  input  logic              host_stb_i,
  output logic [7:0]        host_stat_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int CTL_W = 3;

  logic [CTL_W-1:0]  ctl_s;
  logic [DATA_W-1:0] data_s;
  logic [DATA_W-1:0] rbyte;
  logic              rd_phase, hi_sel;

  ppnib_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({host_sel_i, host_afd_i, host_stb_i}),
    .q_o   (ctl_s)
  );

  ppnib_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (host_data_i),
    .q_o   (data_s)
  );

  ppnib_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (ctl_s[2]),
    .afd_i     (ctl_s[1]),
    .stb_i     (ctl_s[0]),
    .data_i    (data_s),
    .rdata_i   (bus_rdata_i),
    .addr_o    (bus_addr_o),
    .wdata_o   (bus_wdata_o),
    .we_o      (bus_we_o),
    .re_o      (bus_re_o),
    .rbyte_o   (rbyte),
    .rd_phase_o(rd_phase),
    .hi_sel_o  (hi_sel)
  );

  ppnib_nib_enc #(.DATA_W(DATA_W)) u_enc (
    .byte_i  (rbyte),
    .hi_sel_i(hi_sel),
    .en_i    (rd_phase),
    .stat_o  (host_stat_o)
  );
endmodule

// File: tb/ppnib_bridge_bench.sv
module ppnib_bridge_bench;
  localparam int HOLD = 10;
  localparam logic [7:0] FIFO_SEED = 8'h40;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic       host_sel = 1'b1, host_afd = 1'b0, host_stb = 1'b0;
  logic [7:0] host_stat;
  logic [6:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bus_we, bus_re;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0;
  int fifo_wp = 0, fifo_rp = 0;
  logic [7:0] mem [128];
  logic [7:0] fifo_log [16];
  bit done = 0;

  always #4 clk = ~clk;

  ppnib_bridge u_ppnib_bridge (
    .clk_i(clk), .rst_ni(rst_ni), .host_data_i(host_data),
    .host_sel_i(host_sel), .host_afd_i(host_afd), .host_stb_i(host_stb),
    .host_stat_o(host_stat), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_we_o(bus_we), .bus_re_o(bus_re), .bus_rdata_i(bus_rdata)
  );

  function automatic bit is_fifo(input logic [6:0] a);
    return a == 7'h1E || a == 7'h3E || a == 7'h5E;
  endfunction

  // inverse pin map: status 3,4,5,7 -> nibble bits 3,2,1,0
  function automatic logic [3:0] dec_nib(input logic [7:0] s);
    return {s[3], s[4], s[5], s[7]};
  endfunction

  function automatic logic [7:0] exp_stat(input logic [3:0] n);
    logic [7:0] s = 8'h00;
    s[3] = n[3]; s[4] = n[2]; s[5] = n[1]; s[7] = n[0];
    return s;
  endfunction

  always @(posedge clk) begin
    if (bus_we) begin
      wr_cnt++;
      if (is_fifo(bus_addr)) begin fifo_log[fifo_wp % 16] = bus_wdata; fifo_wp++; end
      else mem[bus_addr] = bus_wdata;
    end
    if (bus_re) begin
      rd_cnt++;
      if (is_fifo(bus_addr)) begin bus_rdata <= FIFO_SEED + 8'(fifo_rp); fifo_rp++; end
      else bus_rdata <= mem[bus_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] c);
    @(negedge clk);
    host_sel = c[3]; host_afd = c[1]; host_stb = c[0];
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic dat(input logic [7:0] d);
    @(negedge clk);
    host_data = d;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic host_wr_burst(input logic [6:0] a, input logic [7:0] d0, input int n);
    ctl(8'h1C); ctl(8'h14); dat({1'b0, a});
    for (int i = 0; i < n; i++) begin
      ctl(8'h16); dat(d0 + 8'(i)); ctl(8'h17);
    end
    ctl(8'h14); ctl(8'h1C);
  endtask

  task automatic host_rd_burst(input logic [6:0] a, input int n, output logic [7:0] last);
    ctl(8'h1C); ctl(8'h14); dat({1'b1, a}); ctl(8'h16);
    for (int i = 0; i < n; i++) begin
      logic [3:0] lo;
      ctl(8'h17); lo = dec_nib(host_stat);
      ctl(8'h16); last = {dec_nib(host_stat), lo};
    end
    ctl(8'h14); ctl(8'h1C);
  endtask

  initial begin
    logic [7:0] r, d, lo_stat;
    logic [6:0] a;
    int w0, r0;
    void'($urandom(32'd2718));
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3);
    repeat (3) @(negedge clk);
    chk(host_stat == 8'h00 && !bus_we && !bus_re, "R1", host_stat, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(host_stat == 8'h00 && wr_cnt == 0 && rd_cnt == 0, "R1", wr_cnt + rd_cnt, 0);

    // R10 window addresses with 7-bit wrap
    host_wr_burst(7'h60, 8'hA1, 1); chk(mem[7'h60] == 8'hA1, "R10", mem[7'h60], 8'hA1);
    host_wr_burst(7'h7F, 8'h5B, 1); chk(mem[7'h7F] == 8'h5B, "R10", mem[7'h7F], 8'h5B);
    host_wr_burst(7'h00, 8'hC3, 1); chk(mem[7'h00] == 8'hC3, "R10", mem[7'h00], 8'hC3);
    host_rd_burst(7'h7F, 1, r);     chk(r == 8'h5B, "R10", r, 8'h5B);

    // R3 read bit: bit7 set must not write
    w0 = wr_cnt; r0 = rd_cnt;
    host_rd_burst(7'h20, 1, r);
    chk(wr_cnt == w0 && rd_cnt == r0 + 1, "R3", rd_cnt - r0, 1);
    chk(r == mem[7'h20], "R3", r, mem[7'h20]);

    // R7 raw pin map with single-bit nibbles
    for (int k = 0; k < 4; k++) begin
      mem[7'h11] = 8'(1 << k) | 8'(8'h10 << k);
      ctl(8'h1C); ctl(8'h14); dat(8'h91); ctl(8'h16); ctl(8'h17);
      lo_stat = host_stat;
      chk(lo_stat == exp_stat(4'(1 << k)), "R7 lo", lo_stat, exp_stat(4'(1 << k)));
      ctl(8'h16);
      chk(host_stat == exp_stat(4'(1 << k)), "R7 hi", host_stat, exp_stat(4'(1 << k)));
      ctl(8'h14); ctl(8'h1C);
    end

    // R8 register changes between nibbles
    mem[7'h10] = 8'hA5;
    ctl(8'h1C); ctl(8'h14); dat(8'h90); ctl(8'h16); ctl(8'h17);
    r[3:0] = dec_nib(host_stat);
    mem[7'h10] = 8'h3C;
    ctl(8'h16); r[7:4] = dec_nib(host_stat);
    ctl(8'h14); ctl(8'h1C);
    chk(r == 8'hA5, "R8", r, 8'hA5);

    // R5 burst write to FIFO
    w0 = wr_cnt; fifo_wp = 0;
    host_wr_burst(7'h3E, 8'h70, 4);
    chk(wr_cnt == w0 + 4, "R5", wr_cnt - w0, 4);
    for (int i = 0; i < 4; i++)
      chk(fifo_log[i] == 8'h70 + 8'(i), "R5", fifo_log[i], 8'h70 + 8'(i));
    chk(mem[7'h3E] == 8'(7'h3E * 3), "R5", mem[7'h3E], 8'(7'h3E * 3));

    // R9 burst read from FIFO (wrapped window 0x1E)
    fifo_rp = 0; r0 = rd_cnt;
    host_rd_burst(7'h1E, 5, r);
    chk(rd_cnt == r0 + 5, "R9", rd_cnt - r0, 5);
    chk(r == FIFO_SEED + 8'd4, "R9", r, FIFO_SEED + 8'd4);

    // R11 strobes during address phase
    w0 = wr_cnt; r0 = rd_cnt;
    ctl(8'h1C); ctl(8'h14); dat(8'h05);
    for (int i = 0; i < 3; i++) begin ctl(8'h15); ctl(8'h14); end
    ctl(8'h1C);
    chk(wr_cnt == w0 && rd_cnt == r0, "R11", wr_cnt + rd_cnt, w0 + r0);
    chk(mem[7'h05] == 8'(5 * 3), "R11", mem[7'h05], 8'(5 * 3));

    // R2 abort mid-transaction, strobe while idle, then fresh address
    w0 = wr_cnt;
    ctl(8'h14); dat(8'h06); ctl(8'h16); dat(8'hEE); ctl(8'h1C);
    ctl(8'h1D); ctl(8'h1C); ctl(8'h1D); ctl(8'h1C);
    chk(wr_cnt == w0 && mem[7'h06] == 8'(6 * 3), "R2", wr_cnt - w0, 0);
    ctl(8'h14); dat(8'h07); ctl(8'h16); dat(8'h99); ctl(8'h17); ctl(8'h14); ctl(8'h1C);
    chk(mem[7'h07] == 8'h99 && mem[7'h06] == 8'(6 * 3), "R2", mem[7'h07], 8'h99);
    chk(host_stat == 8'h00, "R2", host_stat, 0);

    // R4 R6 random single write and read-back
    for (int i = 0; i < 30; i++) begin
      a = 7'($urandom % 128);
      if (is_fifo(a)) a = a ^ 7'h01;
      d = 8'($urandom);
      w0 = wr_cnt; r0 = rd_cnt;
      host_wr_burst(a, d, 1);
      chk(mem[a] == d && wr_cnt == w0 + 1, "R4", mem[a], d);
      host_rd_burst(a, 1, r);
      chk(r == d && rd_cnt == r0 + 1, "R6", r, d);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule